// File: doc/BRIEF.md
# Unified Data TLB Lookup with Protection Check

This block is a fully associative translation buffer for data accesses. It holds a parameterised number of page mappings, 64 by default. On each lookup it compares a virtual address against every stored entry at once. Each entry covers a page of one of four sizes. The block then returns either a physical address with the resulting access rights, or a single status code that explains why no translation was given.

A lookup carries five things: the address, the current address-space tag, a flag that turns tag checking on, the privilege level and the access direction. The result is evaluated combinationally and captured into output registers on the clock edge that samples the request strobe. Entries are loaded through a one-cycle write port that addresses a slot by index and replaces all of its fields.

Each entry also stores a group of memory attributes: cacheable, write-through, a 3-bit space attribute and a timing bit. These attributes do not influence the lookup. They are passed out unchanged with a successful translation.

Top module: `utlb_xlate`

## Requirements
- R1: Reset clears every entry, so a lookup made after reset and before any entry write reports a miss. During reset `rsp_valid` is 0, `rsp_status` is 0, `rsp_pa` is 0 and both rights outputs are 0.
- R2: A lookup strobed on `req_valid` at one rising edge is reflected on the response outputs after that edge, with `rsp_valid` high for exactly that one cycle. When no request is strobed, all response outputs hold their previous values.
- R3: The size code selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. An entry matches an address when the address, with the page-offset bits cleared, equals the entry's page number shifted left by 10 with the same bits cleared.
- R4: On success (`rsp_status` = 0) the physical address is the page frame number shifted left by 10 with the page-offset bits cleared, ORed with the page-offset bits of the virtual address. In the same case `rsp_mem_attr` carries the entry's {cacheable, write-through, space[2:0], timing}.
- R5: An entry whose valid bit is clear never matches.
- R6: An entry that is not shared is skipped when tag checking is on and its tag differs from the request tag. A shared entry, or any entry when tag checking is off, ignores the tag.
- R7: In user mode (`req_priv` = 0), a hit on an entry whose protection bit 1 is clear gives a read violation (status 3) on a read and a write violation (status 4) on a write.
- R8: After the privilege check, a write that hits an entry whose protection bit 0 is clear gives a write violation (status 4). This takes priority over the dirty check.
- R9: A write that passes both protection checks and hits an entry whose dirty bit is clear gives status 5 (initial page write). In that case the physical address, rights and memory attributes are all 0.
- R10: On success `rsp_rd_ok` is 1, and `rsp_wr_ok` equals protection bit 0 ANDed with the dirty bit.
- R11: When no entry matches, the status is 1 for a read and 2 for a write. Any status other than 0 zeroes the physical address, the rights and the memory attributes.
- R12: When two or more entries match, the status is 6 (multiple hit) and no translation is given.
- R13: An entry write with `wr_en` high at an edge replaces every field of the indexed slot. A lookup strobed at the next edge sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W (6) | Slot to write |
| wr_vpn | input | VA_W-10 (22) | Virtual page number |
| wr_ppn | input | PA_W-10 (19) | Physical frame number |
| wr_asid | input | ASID_W (8) | Address-space tag |
| wr_valid | input | 1 | Valid bit |
| wr_size | input | 2 | Page size code |
| wr_share | input | 1 | Shared (tag ignored) |
| wr_prot | input | 2 | Protection key: bit 1 user access, bit 0 writable |
| wr_dirty | input | 1 | Dirty bit |
| wr_mem_attr | input | 6 | {cacheable, write-through, space[2:0], timing} |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | VA_W (32) | Virtual address |
| req_asid | input | ASID_W (8) | Current address-space tag |
| req_asid_chk | input | 1 | Enable tag checking |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_status | output | 3 | 0 ok, 1 read miss, 2 write miss, 3 read violation, 4 write violation, 5 initial write, 6 multiple hit |
| rsp_pa | output | PA_W (29) | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_mem_attr | output | 6 | Memory attributes of the hit entry |

## Verification
Every lookup result is due exactly one rising edge after the strobe. The bench drives the request on a falling edge, releases it on the next falling edge and samples all response outputs at that moment, half a period after the capturing edge. An entry write becomes visible to a lookup strobed at the next edge, so each entry-write task completes before the following lookup is driven. Hold behaviour is checked one further falling edge later, with the strobe low.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   localparam int unsigned BASE_SHIFT = 10;
   localparam int unsigned MATTR_W    = 6;

   typedef enum logic [2:0] {
      XS_OK      = 3'd0,
      XS_RD_MISS = 3'd1,
      XS_WR_MISS = 3'd2,
      XS_RD_VIOL = 3'd3,
      XS_WR_VIOL = 3'd4,
      XS_INIT_WR = 3'd5,
      XS_MULTI   = 3'd6
   } xlate_st_e;

   function automatic int unsigned page_shift(input logic [1:0] sz);
      case (sz)
         2'd0:    return 10;
         2'd1:    return 12;
         2'd2:    return 16;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/utlb_entry_store.sv
module utlb_entry_store
   import utlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 64,
   parameter int unsigned ASID_W      = 8,
   parameter int unsigned VPN_W       = 22,
   parameter int unsigned PPN_W       = 19,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [VPN_W-1:0]    wr_vpn,
   input  logic [PPN_W-1:0]    wr_ppn,
   input  logic [ASID_W-1:0]   wr_asid,
   input  logic                wr_valid,
   input  logic [1:0]          wr_size,
   input  logic                wr_share,
   input  logic [1:0]          wr_prot,
   input  logic                wr_dirty,
   input  logic [MATTR_W-1:0]  wr_mem_attr,
   output logic                ent_valid [NUM_ENTRIES],
   output logic                ent_share [NUM_ENTRIES],
   output logic [1:0]          ent_size  [NUM_ENTRIES],
   output logic [1:0]          ent_prot  [NUM_ENTRIES],
   output logic                ent_dirty [NUM_ENTRIES],
   output logic [MATTR_W-1:0]  ent_mattr [NUM_ENTRIES],
   output logic [ASID_W-1:0]   ent_asid  [NUM_ENTRIES],
   output logic [VPN_W-1:0]    ent_vpn   [NUM_ENTRIES],
   output logic [PPN_W-1:0]    ent_ppn   [NUM_ENTRIES]
);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[g] <= 1'b0;
            ent_share[g] <= 1'b0;
            ent_size[g]  <= '0;
            ent_prot[g]  <= '0;
            ent_dirty[g] <= 1'b0;
            ent_mattr[g] <= '0;
            ent_asid[g]  <= '0;
            ent_vpn[g]   <= '0;
            ent_ppn[g]   <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            ent_valid[g] <= wr_valid;
            ent_share[g] <= wr_share;
            ent_size[g]  <= wr_size;
            ent_prot[g]  <= wr_prot;
            ent_dirty[g] <= wr_dirty;
            ent_mattr[g] <= wr_mem_attr;
            ent_asid[g]  <= wr_asid;
            ent_vpn[g]   <= wr_vpn;
            ent_ppn[g]   <= wr_ppn;
         end
      end
   end

endmodule

// File: rtl/utlb_match.sv
module utlb_match
   import utlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 64,
   parameter int unsigned VA_W        = 32,
   parameter int unsigned ASID_W      = 8,
   localparam int unsigned VPN_W      = VA_W - BASE_SHIFT
)(
   input  logic [VA_W-1:0]     va,
   input  logic [ASID_W-1:0]   asid,
   input  logic                asid_chk,
   input  logic                ent_valid [NUM_ENTRIES],
   input  logic                ent_share [NUM_ENTRIES],
   input  logic [1:0]          ent_size  [NUM_ENTRIES],
   input  logic [ASID_W-1:0]   ent_asid  [NUM_ENTRIES],
   input  logic [VPN_W-1:0]    ent_vpn   [NUM_ENTRIES],
   output logic [NUM_ENTRIES-1:0] hit
);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      logic [VA_W-1:0] off_mask;
      logic [VA_W-1:0] page_base;
      logic            tag_ok;

      always_comb begin
         off_mask  = (VA_W'(1) << page_shift(ent_size[g])) - VA_W'(1);
         page_base = {ent_vpn[g], {BASE_SHIFT{1'b0}}} & ~off_mask;
         tag_ok    = ent_share[g] || !asid_chk || (ent_asid[g] == asid);
         hit[g]    = ent_valid[g] && tag_ok && ((va & ~off_mask) == page_base);
      end
   end

endmodule

// File: rtl/utlb_resolve.sv
module utlb_resolve
   import utlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 64,
   parameter int unsigned PA_W        = 29,
   localparam int unsigned PPN_W      = PA_W - BASE_SHIFT
)(
   input  logic [NUM_ENTRIES-1:0] hit,
   input  logic [PA_W-1:0]        va_low,
   input  logic                   priv,
   input  logic                   write,
   input  logic [1:0]             ent_size  [NUM_ENTRIES],
   input  logic [1:0]             ent_prot  [NUM_ENTRIES],
   input  logic                   ent_dirty [NUM_ENTRIES],
   input  logic [MATTR_W-1:0]     ent_mattr [NUM_ENTRIES],
   input  logic [PPN_W-1:0]       ent_ppn   [NUM_ENTRIES],
   output xlate_st_e              status,
   output logic [PA_W-1:0]        pa,
   output logic                   rd_ok,
   output logic                   wr_ok,
   output logic [MATTR_W-1:0]     mattr
);

   logic               any_hit, multi_hit;
   logic [1:0]         s_size, s_prot;
   logic               s_dirty;
   logic [MATTR_W-1:0] s_mattr;
   logic [PPN_W-1:0]   s_ppn;
   logic [PA_W-1:0]    off_mask;

   // AND-OR select: exact when at most one entry hits
   always_comb begin
      s_size  = '0;
      s_prot  = '0;
      s_dirty = 1'b0;
      s_mattr = '0;
      s_ppn   = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (hit[i]) begin
            s_size  = s_size  | ent_size[i];
            s_prot  = s_prot  | ent_prot[i];
            s_dirty = s_dirty | ent_dirty[i];
            s_mattr = s_mattr | ent_mattr[i];
            s_ppn   = s_ppn   | ent_ppn[i];
         end
      end
   end

   assign any_hit   = |hit;
   assign multi_hit = |(hit & (hit - NUM_ENTRIES'(1)));
   assign off_mask  = (PA_W'(1) << page_shift(s_size)) - PA_W'(1);

   always_comb begin
      status = XS_OK;
      pa     = '0;
      rd_ok  = 1'b0;
      wr_ok  = 1'b0;
      mattr  = '0;
      if (!any_hit) begin
         status = write ? XS_WR_MISS : XS_RD_MISS;
      end else if (multi_hit) begin
         status = XS_MULTI;
      end else if (!priv && !s_prot[1]) begin
         status = write ? XS_WR_VIOL : XS_RD_VIOL;
      end else if (write && !s_prot[0]) begin
         status = XS_WR_VIOL;
      end else if (write && !s_dirty) begin
         status = XS_INIT_WR;
      end else begin
         pa    = ({s_ppn, {BASE_SHIFT{1'b0}}} & ~off_mask) | (va_low & off_mask);
         rd_ok = 1'b1;
         wr_ok = s_prot[0] && s_dirty;
         mattr = s_mattr;
      end
   end

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
   import utlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 64,
   parameter int unsigned VA_W        = 32,
   parameter int unsigned PA_W        = 29,
   parameter int unsigned ASID_W      = 8,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
   localparam int unsigned VPN_W      = VA_W - BASE_SHIFT,
   localparam int unsigned PPN_W      = PA_W - BASE_SHIFT
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [VPN_W-1:0]    wr_vpn,
   input  logic [PPN_W-1:0]    wr_ppn,
   input  logic [ASID_W-1:0]   wr_asid,
   input  logic                wr_valid,
   input  logic [1:0]          wr_size,
   input  logic                wr_share,
   input  logic [1:0]          wr_prot,
   input  logic                wr_dirty,
   input  logic [5:0]          wr_mem_attr,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     req_va,
   input  logic [ASID_W-1:0]   req_asid,
   input  logic                req_asid_chk,
   input  logic                req_priv,
   input  logic                req_write,
   output logic                rsp_valid,
   output logic [2:0]          rsp_status,
   output logic [PA_W-1:0]     rsp_pa,
   output logic                rsp_rd_ok,
   output logic                rsp_wr_ok,
   output logic [5:0]          rsp_mem_attr
);

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("utlb_xlate: NUM_ENTRIES must be at least 2");
   end
   if (VA_W < 21 || PA_W < 21) begin : g_bad_width
      $error("utlb_xlate: address widths must cover a 1 MB page");
   end
   if (PA_W > VA_W) begin : g_bad_pa
      $error("utlb_xlate: PA_W may not exceed VA_W");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("utlb_xlate: ASID_W must be positive");
   end

   logic                ent_valid [NUM_ENTRIES];
   logic                ent_share [NUM_ENTRIES];
   logic [1:0]          ent_size  [NUM_ENTRIES];
   logic [1:0]          ent_prot  [NUM_ENTRIES];
   logic                ent_dirty [NUM_ENTRIES];
   logic [MATTR_W-1:0]  ent_mattr [NUM_ENTRIES];
   logic [ASID_W-1:0]   ent_asid  [NUM_ENTRIES];
   logic [VPN_W-1:0]    ent_vpn   [NUM_ENTRIES];
   logic [PPN_W-1:0]    ent_ppn   [NUM_ENTRIES];

   logic [NUM_ENTRIES-1:0] hit;
   xlate_st_e              nx_status;
   logic [PA_W-1:0]        nx_pa;
   logic                   nx_rd, nx_wr;
   logic [MATTR_W-1:0]     nx_mattr;

   utlb_entry_store #(
      .NUM_ENTRIES(NUM_ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_valid(wr_valid),
      .wr_size(wr_size), .wr_share(wr_share), .wr_prot(wr_prot),
      .wr_dirty(wr_dirty), .wr_mem_attr(wr_mem_attr),
      .ent_valid(ent_valid), .ent_share(ent_share), .ent_size(ent_size),
      .ent_prot(ent_prot), .ent_dirty(ent_dirty), .ent_mattr(ent_mattr),
      .ent_asid(ent_asid), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn)
   );

   utlb_match #(
      .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W)
   ) match_i (
      .va(req_va), .asid(req_asid), .asid_chk(req_asid_chk),
      .ent_valid(ent_valid), .ent_share(ent_share), .ent_size(ent_size),
      .ent_asid(ent_asid), .ent_vpn(ent_vpn), .hit(hit)
   );

   utlb_resolve #(
      .NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W)
   ) resolve_i (
      .hit(hit), .va_low(req_va[PA_W-1:0]), .priv(req_priv), .write(req_write),
      .ent_size(ent_size), .ent_prot(ent_prot), .ent_dirty(ent_dirty),
      .ent_mattr(ent_mattr), .ent_ppn(ent_ppn),
      .status(nx_status), .pa(nx_pa), .rd_ok(nx_rd), .wr_ok(nx_wr),
      .mattr(nx_mattr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_status   <= '0;
         rsp_pa       <= '0;
         rsp_rd_ok    <= 1'b0;
         rsp_wr_ok    <= 1'b0;
         rsp_mem_attr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_status   <= nx_status;
            rsp_pa       <= nx_pa;
            rsp_rd_ok    <= nx_rd;
            rsp_wr_ok    <= nx_wr;
            rsp_mem_attr <= nx_mattr;
         end
      end
   end

endmodule

// File: rtl/utlb_xlate_chk.sv
module utlb_xlate_chk #(
   parameter int unsigned PA_W = 29
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_priv,
   input logic            req_write,
   input logic            rsp_valid,
   input logic [2:0]      rsp_status,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_rd_ok,
   input logic            rsp_wr_ok,
   input logic [5:0]      rsp_mem_attr
);

   assert_rsp_tracks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> ($stable(rsp_status) && $stable(rsp_pa) && $stable(rsp_wr_ok)));

   assert_wr_needs_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wr_ok |-> rsp_rd_ok);

   assert_write_ok_rights_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 3'd0 && $past(req_write)) |-> rsp_wr_ok);

   assert_fail_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_status != 3'd0) |-> (rsp_pa == '0 && !rsp_rd_ok && !rsp_wr_ok && rsp_mem_attr == '0));

   assert_rd_miss_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 3'd1) |-> !$past(req_write));

   assert_wr_miss_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 3'd2) |-> $past(req_write));

   assert_rd_viol_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 3'd3) |-> (!$past(req_priv) && !$past(req_write)));

   assert_init_write_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 3'd5) |-> $past(req_write));

   assert_status_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_status <= 3'd6);

endmodule

bind utlb_xlate utlb_xlate_chk #(.PA_W(PA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
   .req_write(req_write), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
   .rsp_pa(rsp_pa), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
   .rsp_mem_attr(rsp_mem_attr)
);

// File: tb/utlb_xlate_tb_top.sv
`timescale 1ns/1ps
module utlb_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [21:0] wr_vpn = '0;
   logic [18:0] wr_ppn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_size = '0;
   logic        wr_share = 1'b0;
   logic [1:0]  wr_prot = '0;
   logic        wr_dirty = 1'b0;
   logic [5:0]  wr_mem_attr = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [7:0]  req_asid = '0;
   logic        req_asid_chk = 1'b0;
   logic        req_priv = 1'b0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [2:0]  rsp_status;
   logic [28:0] rsp_pa;
   logic        rsp_rd_ok, rsp_wr_ok;
   logic [5:0]  rsp_mem_attr;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   utlb_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_valid(wr_valid),
      .wr_size(wr_size), .wr_share(wr_share), .wr_prot(wr_prot),
      .wr_dirty(wr_dirty), .wr_mem_attr(wr_mem_attr),
      .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid),
      .req_asid_chk(req_asid_chk), .req_priv(req_priv), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
      .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_mem_attr(rsp_mem_attr)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [7:0]  asid;
      logic        chk;
      logic        priv;
      logic        wr;
      logic [2:0]  st;
      logic [28:0] pa;
      logic        rd;
      logic        wok;
      logic [5:0]  attr;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b0, 3'd0, 29'h0002_0234, 1'b1, 1'b1, 6'h2D}, // R3 R4 4KB
      '{32'h0000_1234, 8'd6, 1'b1, 1'b1, 1'b0, 3'd1, 29'h0,         1'b0, 1'b0, 6'h00}, // R6 tag mismatch
      '{32'h0000_1234, 8'd6, 1'b0, 1'b1, 1'b1, 3'd0, 29'h0002_0234, 1'b1, 1'b1, 6'h2D}, // R6 chk off
      '{32'h0000_2000, 8'd5, 1'b1, 1'b1, 1'b0, 3'd1, 29'h0,         1'b0, 1'b0, 6'h00}, // R3 past end
      '{32'h0000_2000, 8'd5, 1'b1, 1'b1, 1'b1, 3'd2, 29'h0,         1'b0, 1'b0, 6'h00}, // R11 write miss
      '{32'h0000_0FFF, 8'd5, 1'b1, 1'b1, 1'b1, 3'd2, 29'h0,         1'b0, 1'b0, 6'h00}, // R11 below start
      '{32'h0010_07FF, 8'd1, 1'b1, 1'b1, 1'b0, 3'd0, 29'h0000_43FF, 1'b1, 1'b0, 6'h00}, // R3 1KB R6 shared
      '{32'h0010_0800, 8'd1, 1'b1, 1'b1, 1'b0, 3'd1, 29'h0,         1'b0, 1'b0, 6'h00}, // R3 1KB end
      '{32'h0010_0400, 8'd1, 1'b1, 1'b1, 1'b1, 3'd4, 29'h0,         1'b0, 1'b0, 6'h00}, // R8 read-only
      '{32'h0010_0400, 8'd1, 1'b1, 1'b0, 1'b1, 3'd4, 29'h0,         1'b0, 1'b0, 6'h00}, // R8 user write
      '{32'h0010_0400, 8'd1, 1'b1, 1'b0, 1'b0, 3'd0, 29'h0000_4000, 1'b1, 1'b0, 6'h00}, // R10 user read
      '{32'h0040_ABCD, 8'd5, 1'b1, 1'b1, 1'b0, 3'd0, 29'h0100_ABCD, 1'b1, 1'b0, 6'h00}, // R3 64KB R10
      '{32'h0040_ABCD, 8'd5, 1'b1, 1'b0, 1'b0, 3'd3, 29'h0,         1'b0, 1'b0, 6'h00}, // R7 read viol
      '{32'h0040_ABCD, 8'd5, 1'b1, 1'b0, 1'b1, 3'd4, 29'h0,         1'b0, 1'b0, 6'h00}, // R7 write viol
      '{32'h0040_ABCD, 8'd5, 1'b1, 1'b1, 1'b1, 3'd5, 29'h0,         1'b0, 1'b0, 6'h00}, // R9 init write
      '{32'h080F_FFFF, 8'd9, 1'b1, 1'b1, 1'b0, 3'd0, 29'h003F_FFFF, 1'b1, 1'b0, 6'h00}, // R3 1MB R4
      '{32'h080F_FFFF, 8'd9, 1'b1, 1'b1, 1'b1, 3'd5, 29'h0,         1'b0, 1'b0, 6'h00}, // R9
      '{32'h0810_0000, 8'd9, 1'b1, 1'b1, 1'b0, 3'd1, 29'h0,         1'b0, 1'b0, 6'h00}, // R3 1MB end
      '{32'h0900_0010, 8'd0, 1'b0, 1'b1, 1'b0, 3'd1, 29'h0,         1'b0, 1'b0, 6'h00}, // R5 invalid
      '{32'h0A00_4010, 8'd0, 1'b1, 1'b1, 1'b0, 3'd6, 29'h0,         1'b0, 1'b0, 6'h00}, // R12 multi
      '{32'h0A01_0000, 8'd3, 1'b1, 1'b0, 1'b1, 3'd0, 29'h0051_0000, 1'b1, 1'b1, 6'h00}  // R4 single of pair
   };

   task automatic put_entry(input int idx, input logic [21:0] vpn, input logic [18:0] ppn,
                            input logic [7:0] asid, input logic v, input logic [1:0] sz,
                            input logic sh, input logic [1:0] pr, input logic d,
                            input logic [5:0] attr);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid;
      wr_valid = v; wr_size = sz; wr_share = sh; wr_prot = pr; wr_dirty = d;
      wr_mem_attr = attr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic chk,
                         input logic priv, input logic wr);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_asid = asid; req_asid_chk = chk;
      req_priv = priv; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input logic [2:0] st, input logic [28:0] pa,
                             input logic rd, input logic wok, input logic [5:0] attr);
      n_checks++;
      if (rsp_valid !== 1'b1 || rsp_status !== st || rsp_pa !== pa ||
          rsp_rd_ok !== rd || rsp_wr_ok !== wok || rsp_mem_attr !== attr) begin
         n_fails++;
         $display("FAIL %s: got v=%0b st=%0d pa=%h rd=%0b wr=%0b attr=%h, expected v=1 st=%0d pa=%h rd=%0b wr=%0b attr=%h",
                  tag, rsp_valid, rsp_status, rsp_pa, rsp_rd_ok, rsp_wr_ok, rsp_mem_attr,
                  st, pa, rd, wok, attr);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(5ns * 100000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (rsp_valid !== 1'b0 || rsp_status !== 3'd0 || rsp_pa !== '0 ||
          rsp_rd_ok !== 1'b0 || rsp_wr_ok !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset outputs: got v=%0b st=%0d pa=%h, expected all zero",
                  rsp_valid, rsp_status, rsp_pa);
      end
      rst_n = 1'b1;

      // R1: empty table misses
      lookup(32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b0);
      expect_rsp("R1 empty miss", 3'd1, '0, 1'b0, 1'b0, 6'h00);

      put_entry(0,  22'h4,     19'h80,   8'd5,  1'b1, 2'd1, 1'b0, 2'd3, 1'b1, 6'h2D);
      put_entry(1,  22'h401,   19'h10,   8'h77, 1'b1, 2'd0, 1'b1, 2'd2, 1'b1, 6'h00);
      put_entry(2,  22'h1000,  19'h4000, 8'd5,  1'b1, 2'd2, 1'b0, 2'd1, 1'b0, 6'h00);
      put_entry(3,  22'h20000, 19'hC00,  8'd9,  1'b1, 2'd3, 1'b0, 2'd3, 1'b0, 6'h00);
      put_entry(4,  22'h24000, 19'h7,    8'd0,  1'b0, 2'd3, 1'b1, 2'd3, 1'b1, 6'h3F);
      put_entry(5,  22'h28000, 19'h1400, 8'd0,  1'b1, 2'd3, 1'b1, 2'd3, 1'b1, 6'h00);
      put_entry(63, 22'h28010, 19'h2,    8'd0,  1'b1, 2'd1, 1'b1, 2'd3, 1'b1, 6'h00);

      for (int i = 0; i < NV; i++) begin
         lookup(VECS[i].va, VECS[i].asid, VECS[i].chk, VECS[i].priv, VECS[i].wr);
         expect_rsp($sformatf("vector %0d (R3-R12 table)", i), VECS[i].st, VECS[i].pa,
                    VECS[i].rd, VECS[i].wok, VECS[i].attr);
      end

      // R2: one-cycle valid, outputs hold when idle
      lookup(32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      n_checks++;
      if (rsp_valid !== 1'b0 || rsp_status !== 3'd0 || rsp_pa !== 29'h0002_0234) begin
         n_fails++;
         $display("FAIL R2 hold: got v=%0b st=%0d pa=%h, expected v=0 st=0 pa=00020234",
                  rsp_valid, rsp_status, rsp_pa);
      end

      // R13: overwrite slot 0 with clean page, then invalidate it
      put_entry(0, 22'h4, 19'h80, 8'd5, 1'b1, 2'd1, 1'b0, 2'd3, 1'b0, 6'h11);
      lookup(32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b1);
      expect_rsp("R13 rewrite to clean", 3'd5, '0, 1'b0, 1'b0, 6'h00);
      lookup(32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b0);
      expect_rsp("R13 rewrite read", 3'd0, 29'h0002_0234, 1'b1, 1'b0, 6'h11);
      put_entry(0, 22'h4, 19'h80, 8'd5, 1'b0, 2'd1, 1'b0, 2'd3, 1'b1, 6'h00);
      lookup(32'h0000_1234, 8'd5, 1'b1, 1'b1, 1'b0);
      expect_rsp("R13 R5 invalidated", 3'd1, '0, 1'b0, 1'b0, 6'h00);

      // R1: reset clears loaded entries
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      lookup(32'h0A01_0000, 8'd0, 1'b0, 1'b1, 1'b0);
      expect_rsp("R1 after re-reset", 3'd1, '0, 1'b0, 1'b0, 6'h00);

      finish_run();
   end

endmodule